// File: doc/BRIEF.md
# VLIW ALU Group Decoder

This block takes a stream of 32-bit words for a very-long-instruction-word ALU and splits it into instruction groups. Each instruction slot is two words. The first word of the final slot has bit 31 set, and a group holds no more than five slots. For every slot the decoder produces one registered record. The record carries the source operand fields, the destination fields, the opcode, the operand form (two or three operands), and the execution unit the slot is assigned to. Lanes x, y, z and w map to units 0 to 3. Unit 4 is a scalar unit that takes slots whose lane is already occupied, as well as transcendental operations.

Literal constants follow a group directly in the stream. The decoder records which literal channels the sources of the group referenced, and it absorbs two or four literal words accordingly. Each absorbed word is presented on a separate literal output. When a group has fully retired, the decoder pulses an end-of-group strobe and publishes the set of units the group wrote. A downstream stage uses this set to resolve forwarding for the next group. The decoder also keeps a word pointer that counts every accepted word. A malformed group raises a sticky error and stops input.

Top module: `vliw_group_decoder`

## Requirements
- R1: A word is accepted on a clock edge where in_valid and in_ready are both high. Accepted words pair up into slots, first word then second word. The slot record is presented, with slot_valid high, in the cycle after its second word is accepted. slot_last is set to bit 31 of the slot's first word, and slot_idx counts the slots within the group from 0.
- R2: The fields of the first word pass through unchanged. slot_src0 = word0[12:0] and slot_src1 = word0[25:13], each packed as {negate, channel[1:0], relative, select[8:0]}. slot_index_mode = word0[28:26] and slot_pred = word0[30:29].
- R3: If second-word bits [17:13] are 8 or greater, the slot is three-operand (slot_op3=1). In that case slot_opcode = {6'b0, w1[17:13]}, slot_src2 = w1[12:0], slot_wren=1, and abs, omod and both update flags are 0. Otherwise slot_opcode = w1[17:7], slot_src2 = 0, slot_abs = w1[1:0], slot_upd_exec = w1[2], slot_upd_pred = w1[3], slot_wren = w1[4] and slot_omod = w1[6:5], where 0 means none, 1 means x2, 2 means x4 and 3 means /2. For both forms, the destination register is w1[27:21], the relative flag w1[28], the lane w1[30:29] and the clamp w1[31].
- R4: A slot is assigned to the unit equal to its lane, unless an earlier slot of the same group already claimed that lane. In that case the slot goes to unit 4.
- R5: A two-operand opcode in the range TRANS_LO..TRANS_HI (default 0x060..0x07F) always goes to unit 4. The slot still claims its lane.
- R6: A source references a literal when its 9-bit select equals LIT_SEL (default 253). Sources 0 and 1 always count. Source 2 counts only for three-operand slots. Channels x and y mark the low pair and channels z and w mark the high pair. After the last slot, the decoder absorbs 2 words for each marked pair, giving 0, 2 or 4 words. Each absorbed word appears on lit_word with lit_valid high one cycle after it is accepted, and lit_idx counts 0, 1, 2, 3 within the run.
- R7: The lane-claim set and the literal-reference set are both cleared at every group boundary.
- R8: grp_end pulses for one cycle when a group retires. That cycle coincides with the last slot record if the group has no literals, and with the last literal otherwise. In the same cycle, prev_units shows bit u set exactly when some slot of that group used unit u. prev_units changes at no other time.
- R9: If the first word of the fifth slot has bit 31 clear, err is set. err stays set until reset, and in_ready is held low while err is set.
- R10: ip increments by one for every accepted word, so it advances by two per slot plus one per literal word.
- R11: After reset, in_ready=1, ip=0, err=0, prev_units=0, and slot_valid, lit_valid and grp_end are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Decoder accepts a word |
| in_word | input | 32 | Instruction or literal word |
| slot_valid | output | 1 | Slot record valid |
| slot_idx | output | 3 | Slot position within group |
| slot_unit | output | 3 | Assigned unit, 0..4 |
| slot_op3 | output | 1 | Three-operand form |
| slot_opcode | output | 11 | Opcode |
| slot_src0 | output | 13 | Source 0 {neg, chan, rel, sel} |
| slot_src1 | output | 13 | Source 1 {neg, chan, rel, sel} |
| slot_src2 | output | 13 | Source 2, zero for two-operand |
| slot_abs | output | 2 | Abs flags for sources 1 and 0 |
| slot_index_mode | output | 3 | Index mode |
| slot_pred | output | 2 | Predicate select |
| slot_dst_gpr | output | 7 | Destination register |
| slot_dst_rel | output | 1 | Destination relative flag |
| slot_dst_lane | output | 2 | Destination lane |
| slot_clamp | output | 1 | Clamp flag |
| slot_wren | output | 1 | Register write enable |
| slot_upd_exec | output | 1 | Update execute mask |
| slot_upd_pred | output | 1 | Update predicate |
| slot_omod | output | 2 | Output modifier |
| slot_last | output | 1 | Last slot of group |
| lit_valid | output | 1 | Literal word valid |
| lit_idx | output | 2 | Literal position in run |
| lit_word | output | 32 | Literal word |
| grp_end | output | 1 | Group retired strobe |
| prev_units | output | 5 | Units written by the retired group |
| ip | output | IPW | Accepted-word pointer |
| err | output | 1 | Sticky malformed-group error |

## Verification
The bench focuses on the following corner cases:
- Lane collisions within a group. A decoder that ignores the claim set would place two slots on one vector unit.
- A transcendental slot followed by a slot on the same lane. A decoder that fails to record the claim would send the second slot to its lane rather than to unit 4.
- Literal runs of zero, two and four words. These include a reference carried only through source 2 of a three-operand slot, a reference only to the high pair, and a two-operand slot whose second word happens to hold the literal select pattern. A wrong literal count shifts every later word, so all subsequent slot records come out corrupted.
- A group that follows a literal-using group. A decoder that failed to clear the sets between groups would swallow instruction words as literals.
- The five-slot limit. The bench checks the error flag and confirms that the stalled input is ignored.

// File: rtl/vliw_group_decoder.sv
module vliw_group_decoder #(
  parameter int          IPW       = 16,
  parameter int          MAX_SLOTS = 5,
  parameter logic [8:0]  LIT_SEL   = 9'd253,
  parameter logic [10:0] TRANS_LO  = 11'h060,
  parameter logic [10:0] TRANS_HI  = 11'h07F
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [31:0]    in_word,
  output logic           slot_valid,
  output logic [2:0]     slot_idx,
  output logic [2:0]     slot_unit,
  output logic           slot_op3,
  output logic [10:0]    slot_opcode,
  output logic [12:0]    slot_src0,
  output logic [12:0]    slot_src1,
  output logic [12:0]    slot_src2,
  output logic [1:0]     slot_abs,
  output logic [2:0]     slot_index_mode,
  output logic [1:0]     slot_pred,
  output logic [6:0]     slot_dst_gpr,
  output logic           slot_dst_rel,
  output logic [1:0]     slot_dst_lane,
  output logic           slot_clamp,
  output logic           slot_wren,
  output logic           slot_upd_exec,
  output logic           slot_upd_pred,
  output logic [1:0]     slot_omod,
  output logic           slot_last,
  output logic           lit_valid,
  output logic [1:0]     lit_idx,
  output logic [31:0]    lit_word,
  output logic           grp_end,
  output logic [4:0]     prev_units,
  output logic [IPW-1:0] ip,
  output logic           err
);

  localparam logic [2:0] LAST_SLOT = 3'(MAX_SLOTS - 1);
  localparam logic [2:0] SCALAR    = 3'd4;

  typedef enum logic [1:0] {P_W0, P_W1, P_LIT} phase_t;

  phase_t      phase;
  logic [31:0] w0_q;
  logic [2:0]  slot_q;
  logic [3:0]  lane_q;
  logic [1:0]  ref_q;
  logic [4:0]  units_q;
  logic [2:0]  lit_left;
  logic [1:0]  lit_pos;

  logic        acc, op3, trans;
  logic [10:0] opc;
  logic [1:0]  lane;
  logic [2:0]  unit;
  logic [1:0]  refs_new, refs_all;
  logic [2:0]  nlit;
  logic [4:0]  units_nx;

  assign in_ready = !err;
  assign acc      = in_valid && in_ready;
  assign op3      = in_word[17:13] >= 5'd8;
  assign opc      = op3 ? {6'b0, in_word[17:13]} : in_word[17:7];
  assign lane     = in_word[30:29];
  assign trans    = !op3 && opc >= TRANS_LO && opc <= TRANS_HI;
  assign unit     = (trans || lane_q[lane]) ? SCALAR : {1'b0, lane};
  assign units_nx = units_q | (5'b1 << unit);

  always_comb begin
    refs_new = 2'b00;
    if (w0_q[8:0] == LIT_SEL)          refs_new[w0_q[11]]    = 1'b1;
    if (w0_q[21:13] == LIT_SEL)        refs_new[w0_q[24]]    = 1'b1;
    if (op3 && in_word[8:0] == LIT_SEL) refs_new[in_word[11]] = 1'b1;
  end

  assign refs_all = ref_q | refs_new;
  assign nlit     = {refs_all[0] & refs_all[1], refs_all[0] ^ refs_all[1], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= P_W0; w0_q <= '0; slot_q <= '0; lane_q <= '0; ref_q <= '0;
      units_q <= '0; lit_left <= '0; lit_pos <= '0;
      slot_valid <= 1'b0; slot_idx <= '0; slot_unit <= '0; slot_op3 <= 1'b0;
      slot_opcode <= '0; slot_src0 <= '0; slot_src1 <= '0; slot_src2 <= '0;
      slot_abs <= '0; slot_index_mode <= '0; slot_pred <= '0; slot_dst_gpr <= '0;
      slot_dst_rel <= 1'b0; slot_dst_lane <= '0; slot_clamp <= 1'b0; slot_wren <= 1'b0;
      slot_upd_exec <= 1'b0; slot_upd_pred <= 1'b0; slot_omod <= '0; slot_last <= 1'b0;
      lit_valid <= 1'b0; lit_idx <= '0; lit_word <= '0; grp_end <= 1'b0;
      prev_units <= '0; ip <= '0; err <= 1'b0;
    end else begin
      slot_valid <= 1'b0;
      lit_valid  <= 1'b0;
      grp_end    <= 1'b0;
      if (acc) begin
        ip <= ip + 1'b1;
        case (phase)
          P_W0: begin
            w0_q  <= in_word;
            phase <= P_W1;
            if (slot_q == LAST_SLOT && !in_word[31]) err <= 1'b1;
          end
          P_W1: begin
            slot_valid      <= 1'b1;
            slot_idx        <= slot_q;
            slot_unit       <= unit;
            slot_op3        <= op3;
            slot_opcode     <= opc;
            slot_src0       <= w0_q[12:0];
            slot_src1       <= w0_q[25:13];
            slot_src2       <= op3 ? in_word[12:0] : 13'd0;
            slot_abs        <= op3 ? 2'b00 : in_word[1:0];
            slot_index_mode <= w0_q[28:26];
            slot_pred       <= w0_q[30:29];
            slot_dst_gpr    <= in_word[27:21];
            slot_dst_rel    <= in_word[28];
            slot_dst_lane   <= lane;
            slot_clamp      <= in_word[31];
            slot_wren       <= op3 ? 1'b1 : in_word[4];
            slot_upd_exec   <= !op3 && in_word[2];
            slot_upd_pred   <= !op3 && in_word[3];
            slot_omod       <= op3 ? 2'b00 : in_word[6:5];
            slot_last       <= w0_q[31];
            if (w0_q[31]) begin
              slot_q <= '0;
              lane_q <= '0;
              ref_q  <= '0;
              if (nlit == 3'd0) begin
                grp_end    <= 1'b1;
                prev_units <= units_nx;
                units_q    <= '0;
                phase      <= P_W0;
              end else begin
                units_q  <= units_nx;
                lit_left <= nlit;
                lit_pos  <= '0;
                phase    <= P_LIT;
              end
            end else begin
              slot_q  <= slot_q + 1'b1;
              lane_q  <= lane_q | (4'b1 << lane);
              ref_q   <= refs_all;
              units_q <= units_nx;
              phase   <= P_W0;
            end
          end
          default: begin
            lit_valid <= 1'b1;
            lit_word  <= in_word;
            lit_idx   <= lit_pos;
            lit_pos   <= lit_pos + 1'b1;
            lit_left  <= lit_left - 1'b1;
            if (lit_left == 3'd1) begin
              grp_end    <= 1'b1;
              prev_units <= units_q;
              units_q    <= '0;
              phase      <= P_W0;
            end
          end
        endcase
      end
    end
  end

  AST_UNIT_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid && slot_unit != SCALAR |-> slot_unit[1:0] == slot_dst_lane && slot_unit[2] == 1'b0); // R4
  AST_TRANS_SCALAR: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid && !slot_op3 && slot_opcode >= TRANS_LO && slot_opcode <= TRANS_HI |-> slot_unit == SCALAR); // R5
  AST_LIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    lit_valid |-> !slot_valid); // R6
  AST_END_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    grp_end && slot_valid |-> slot_last); // R1
  AST_PREV_ONLY_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prev_units) |-> grp_end); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R9
  AST_ERR_READY: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !in_ready); // R9
  AST_IP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> ip == $past(ip) + 1'b1); // R10

endmodule

// File: tb/vliw_group_decoder_test.sv
module vliw_group_decoder_test;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic in_ready, slot_valid, slot_op3, slot_dst_rel, slot_clamp, slot_wren;
  logic slot_upd_exec, slot_upd_pred, slot_last, lit_valid, grp_end, err;
  logic [2:0] slot_idx, slot_unit, slot_index_mode;
  logic [10:0] slot_opcode;
  logic [12:0] slot_src0, slot_src1, slot_src2;
  logic [1:0] slot_abs, slot_pred, slot_dst_lane, slot_omod, lit_idx;
  logic [6:0] slot_dst_gpr;
  logic [31:0] lit_word;
  logic [4:0] prev_units;
  logic [15:0] ip;

  vliw_group_decoder uut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, words = 0;
  logic [77:0] exp_slot[$];
  logic [33:0] exp_lit[$];
  logic [4:0]  exp_grp[$];
  logic [3:0]  m_lane;
  logic [1:0]  m_ref;
  logic [4:0]  m_units;
  int          m_nlit;
  logic [2:0]  m_idx;

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] w0f(bit stop, logic [8:0] s0, logic [1:0] c0, logic [8:0] s1, logic [1:0] c1);
    return {stop, 2'b01, 3'b010, 1'b1, c1, 1'b0, s1, 1'b0, c0, 1'b1, s0};
  endfunction
  function automatic logic [31:0] w1op2(logic [10:0] opc, logic [1:0] lane, logic [6:0] gpr, logic [6:0] low);
    return {1'b0, lane, 1'b1, gpr, 3'b000, opc, low};
  endfunction
  function automatic logic [31:0] w1op3(logic [4:0] op5, logic [1:0] lane, logic [6:0] gpr, logic [8:0] s2, logic [1:0] c2);
    return {1'b1, lane, 1'b0, gpr, 3'b000, op5, 1'b0, c2, 1'b1, s2};
  endfunction

  task automatic put(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(posedge clk);
    words++;
    #1 in_valid = 1'b0;
  endtask

  task automatic slot(input logic [31:0] w0, input logic [31:0] w1);
    bit op3, tr;
    logic [10:0] opc;
    logic [2:0] u;
    logic [1:0] ln;
    op3 = w1[17:13] >= 5'd8;
    opc = op3 ? {6'b0, w1[17:13]} : w1[17:7];
    ln  = w1[30:29];
    tr  = !op3 && opc >= 11'h060 && opc <= 11'h07F;
    u   = (tr || m_lane[ln]) ? 3'd4 : {1'b0, ln};
    m_lane[ln] = 1'b1;
    m_units[u] = 1'b1;
    if (w0[8:0] == 9'd253) m_ref[w0[11]] = 1'b1;
    if (w0[21:13] == 9'd253) m_ref[w0[24]] = 1'b1;
    if (op3 && w1[8:0] == 9'd253) m_ref[w1[11]] = 1'b1;
    exp_slot.push_back({u, op3, opc, w1[27:21], ln, op3 ? 1'b1 : w1[4], op3 ? 2'b00 : w1[6:5],
                        w0[31], w0[12:0], w0[25:13], op3 ? w1[12:0] : 13'd0, op3 ? 2'b00 : w1[1:0],
                        w0[28:26], w0[30:29], w1[31], w1[28], !op3 && w1[2], !op3 && w1[3]});
    if (w0[31]) begin
      m_nlit = (m_ref[0] ? 2 : 0) + (m_ref[1] ? 2 : 0);
      exp_grp.push_back(m_units);
      m_lane = '0; m_ref = '0; m_units = '0;
    end
    put(w0);
    put(w1);
    if (w0[31]) begin
      for (int i = 0; i < m_nlit; i++) begin
        exp_lit.push_back({2'(i), 32'hC0DE_0000 + words});
        put(32'hC0DE_0000 + words);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && slot_valid) begin
      logic [77:0] a, e;
      a = {slot_unit, slot_op3, slot_opcode, slot_dst_gpr, slot_dst_lane, slot_wren, slot_omod,
           slot_last, slot_src0, slot_src1, slot_src2, slot_abs, slot_index_mode, slot_pred,
           slot_clamp, slot_dst_rel, slot_upd_exec, slot_upd_pred};
      e = exp_slot.size() ? exp_slot.pop_front() : '1;
      chk(a == e, "R1 R2 R3 R4 R5 slot record", 96'(a), 96'(e));
      chk(slot_idx == m_idx, "R1 slot_idx", 96'(slot_idx), 96'(m_idx));
      m_idx = slot_last ? 3'd0 : m_idx + 1'b1;
    end
    if (rst_n && lit_valid) begin
      logic [33:0] e;
      e = exp_lit.size() ? exp_lit.pop_front() : '1;
      chk({lit_idx, lit_word} == e, "R6 literal word", 96'({lit_idx, lit_word}), 96'(e));
    end
    if (rst_n && grp_end) begin
      logic [4:0] e;
      e = exp_grp.size() ? exp_grp.pop_front() : 5'h1F;
      chk(prev_units == e, "R8 prev_units", 96'(prev_units), 96'(e));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] ip_hold;
    m_lane = '0; m_ref = '0; m_units = '0; m_nlit = 0; m_idx = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(in_ready && ip == 0 && !err && prev_units == 0 && !slot_valid && !lit_valid && !grp_end,
        "R11 reset state", 96'({in_ready, ip, err, prev_units, slot_valid, lit_valid, grp_end}), 96'(0));
    rst_n = 1'b1;
    slot(w0f(1, 9'd5, 2'd0, 9'd6, 2'd1), w1op2(11'h019, 2'd0, 7'd3, 7'h35));            // R4 lone slot
    slot(w0f(0, 9'd1, 2'd2, 9'd2, 2'd3), w1op2(11'h019, 2'd1, 7'd4, 7'h10));             // R4
    slot(w0f(1, 9'd7, 2'd1, 9'd8, 2'd0), w1op2(11'h011, 2'd1, 7'd9, 7'h4A));             // R4 collision
    slot(w0f(1, 9'd3, 2'd0, 9'd4, 2'd0), w1op2(11'h019, 2'd1, 7'd1, 7'h10));             // R7 cleared
    slot(w0f(0, 9'd3, 2'd0, 9'd4, 2'd0), w1op2(11'h066, 2'd2, 7'd2, 7'h10));             // R5 trans
    slot(w0f(1, 9'd3, 2'd0, 9'd4, 2'd0), w1op2(11'h019, 2'd2, 7'd2, 7'h10));             // R5 claimed lane
    slot(w0f(1, 9'd253, 2'd0, 9'd4, 2'd0), w1op2(11'h019, 2'd0, 7'd2, 7'h10));           // R6 two literals
    slot(w0f(1, 9'd3, 2'd0, 9'd4, 2'd0), w1op2(11'h019, 2'd3, 7'd5, 7'h7D));             // R6 R7 op2 w1 pattern ignored
    slot(w0f(0, 9'd3, 2'd0, 9'd4, 2'd0), w1op3(5'h0C, 2'd0, 7'd6, 9'd253, 2'd3));        // R3 R6 src2 literal
    slot(w0f(1, 9'd3, 2'd0, 9'd253, 2'd1), w1op3(5'h10, 2'd1, 7'd7, 9'd12, 2'd0));       // R6 four literals
    slot(w0f(1, 9'd3, 2'd0, 9'd253, 2'd2), w1op2(11'h019, 2'd2, 7'd8, 7'h20));           // R6 high pair only
    for (int i = 0; i < 5; i++)
      slot(w0f(i == 4, 9'd10, 2'(i), 9'd11, 2'd0), w1op2(11'h019, 2'(i % 4), 7'(20 + i), 7'h10)); // R1 R4 five slots
    repeat (2) @(negedge clk);
    chk(ip == 16'(words), "R10 ip count", 96'(ip), 96'(words));
    chk(!err, "R9 no error for valid groups", 96'(err), 96'(0));
    for (int i = 0; i < 4; i++)
      slot(w0f(0, 9'd10, 2'd0, 9'd11, 2'd0), w1op2(11'h019, 2'(i), 7'(i), 7'h10));
    put(w0f(0, 9'd10, 2'd0, 9'd11, 2'd0));
    @(negedge clk);
    chk(err && !in_ready, "R9 fifth slot without stop", 96'({err, in_ready}), 96'(2'b10));
    ip_hold = ip;
    @(negedge clk);
    in_valid = 1'b1; in_word = w1op2(11'h019, 2'd0, 7'd0, 7'h10);
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    chk(ip == ip_hold && err && !slot_valid, "R9 R10 input ignored while in error", 96'(ip), 96'(ip_hold));
    chk(exp_slot.size() == 0 && exp_lit.size() == 0 && exp_grp.size() == 0, "R1 R6 R8 scoreboard drained",
        96'(exp_slot.size() + exp_lit.size() + exp_grp.size()), 96'(0));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule